// File: doc/BRIEF.md
# Knockout Cell Concentrator

The block collects ATM cells offered on `IN_LANES` input lanes into a small store of at most `CONC` cells, where `CONC` is the internal concentration factor. It admits cells until that store is full and refuses every further cell, flagging each refused cell on a per-lane drop pulse and adding it to a saturating drop tally. When the synchronizing tick arrives, the block takes a snapshot of the store. One cycle later it presents that snapshot as a burst on `CONC` output lanes, where `CONC` is smaller than `IN_LANES`, and it empties the store at the same time.

Each newly admitted cell becomes the head of the store. When several inputs carry cells in one cycle, they are admitted in ascending lane order, so the highest-numbered admitted lane ends up at the head. On unload the head goes to the highest output lane and older cells fill the lanes below it. Output lanes without a cell keep their valid flag low. A cell that arrives in the same cycle as the tick is not part of that snapshot; it is held for the following tick.

Top module: `kc_concentrator`

## Requirements
- R1: While reset is asserted and directly after it, all output valid flags, `latched_o`, every drop pulse and the drop count are zero.
- R2: The store never holds more than `CONC` cells. A valid input cell that finds no free slot is dropped, and the matching bit of `drop_o` is high exactly one cycle after the cell was offered.
- R3: Cells offered in the same cycle are admitted in ascending input-lane order while free slots remain. The lower-numbered lanes win, and the higher-numbered lanes beyond the free space are dropped.
- R4: One cycle after `sync_i` is high, `latched_o` pulses high for one cycle and the output lanes carry the store contents as they stood before that cycle's arrivals.
- R5: On unload, the most recently admitted cell appears on output lane `CONC-1` and each older cell on the next lower lane. The valid lanes therefore form a contiguous group at the top, and the lanes below that group have their valid flag low.
- R6: A tick empties the store. A following tick with no arrivals in between yields no valid output lane.
- R7: A cell that arrives in the same cycle as `sync_i` is excluded from that unload, is admitted into the emptied store, and is delivered on the next tick.
- R8: `drop_cnt_o` increases by the number of cells dropped in a cycle, one cycle after that cycle, and saturates at its all-ones value.
- R9: In every cycle other than the one after a tick, all output valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Synchronizing tick: snapshot and unload the store |
| in_vld_i | input | IN_LANES | Per-lane cell valid |
| in_cell_i | input | IN_LANES x 56 | Per-lane cell: bits 55:48 VPI, 47:32 VCI, 31:0 data |
| out_vld_o | output | CONC | Per-output-lane valid, only in the cycle after a tick |
| out_cell_o | output | CONC x 56 | Per-output-lane cell, same field layout as the inputs |
| latched_o | output | 1 | One-cycle pulse when an unload burst is presented |
| drop_o | output | IN_LANES | Per-lane pulse, one cycle after a refused cell |
| drop_cnt_o | output | CNT_W | Saturating count of refused cells |

## Verification
The hardest case to reach is a tick that falls on a cycle where the store is full and new cells are arriving. That single cycle must take the full snapshot, clear the store, and still admit the arrivals, without dropping any of them. The stimulus builds the store up to capacity with directed cycles and then raises the tick together with several input cells. It then fires two more ticks to show that the arrivals were held back and then drained. Random stimulus, with a tick on about one cycle in five and input lanes that are half loaded, revisits this overlap many times at varying fill levels. A long flood of full-width arrivals drives the drop tally into saturation.

// File: rtl/kc_pkg.sv
`timescale 1ns/1ps
package kc_pkg;
    localparam int VPI_W  = 8;
    localparam int VCI_W  = 16;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [VPI_W-1:0]  vpi;
        logic [VCI_W-1:0]  vci;
        logic [DATA_W-1:0] data;
    } cell_t;

    localparam int CELL_W = $bits(cell_t);
endpackage

// File: rtl/kc_admit.sv
`timescale 1ns/1ps
module kc_admit #(
    parameter int IN_LANES = 4,
    parameter int CONC     = 3,
    localparam int CW      = $clog2(CONC + 1)
) (
    input  logic [IN_LANES-1:0] vld_i,
    input  logic [CW-1:0]       free_i,
    output logic [IN_LANES-1:0] admit_o,
    output logic [IN_LANES-1:0] drop_o
);
    always_comb begin
        int taken;
        taken   = 0;
        admit_o = '0;
        drop_o  = '0;
        for (int i = 0; i < IN_LANES; i++) begin
            if (vld_i[i]) begin
                if (taken < int'(free_i)) begin
                    admit_o[i] = 1'b1;
                    taken      = taken + 1;
                end else begin
                    drop_o[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/kc_store.sv
`timescale 1ns/1ps
module kc_store
    import kc_pkg::*;
#(
    parameter int IN_LANES = 4,
    parameter int CONC     = 3,
    localparam int CW      = $clog2(CONC + 1)
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     clear_i,
    input  logic [IN_LANES-1:0]      admit_i,
    input  cell_t [IN_LANES-1:0]     cells_i,
    output cell_t [CONC-1:0]         slot_o,
    output logic [CW-1:0]            cnt_o
);
    cell_t [CONC-1:0] slot_q, nxt_slot;
    logic [CW-1:0]    cnt_q, nxt_cnt;

    // slot 0 is the head; every admission pushes older entries one deeper
    always_comb begin
        nxt_slot = clear_i ? '0 : slot_q;
        nxt_cnt  = clear_i ? '0 : cnt_q;
        for (int i = 0; i < IN_LANES; i++) begin
            if (admit_i[i]) begin
                for (int k = CONC - 1; k > 0; k--) begin
                    nxt_slot[k] = nxt_slot[k-1];
                end
                nxt_slot[0] = cells_i[i];
                nxt_cnt     = nxt_cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q <= '0;
            cnt_q  <= '0;
        end else begin
            slot_q <= nxt_slot;
            cnt_q  <= nxt_cnt;
        end
    end

    assign slot_o = slot_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/kc_unload.sv
`timescale 1ns/1ps
module kc_unload
    import kc_pkg::*;
#(
    parameter int CONC = 3,
    localparam int CW  = $clog2(CONC + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sync_i,
    input  cell_t [CONC-1:0] slot_i,
    input  logic [CW-1:0]    cnt_i,
    output logic [CONC-1:0]  vld_o,
    output cell_t [CONC-1:0] cell_o,
    output logic             latched_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vld_o     <= '0;
            cell_o    <= '0;
            latched_o <= 1'b0;
        end else begin
            latched_o <= sync_i;
            if (sync_i) begin
                // head lands on the top lane, lane index counts down
                for (int j = 0; j < CONC; j++) begin
                    vld_o[CONC-1-j]  <= (CW'(j) < cnt_i);
                    cell_o[CONC-1-j] <= slot_i[j];
                end
            end else begin
                vld_o <= '0;
            end
        end
    end
endmodule

// File: rtl/kc_drop_ctr.sv
`timescale 1ns/1ps
module kc_drop_ctr #(
    parameter int IN_LANES = 4,
    parameter int CNT_W    = 6
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [IN_LANES-1:0] drop_i,
    output logic [IN_LANES-1:0] drop_o,
    output logic [CNT_W-1:0]    cnt_o
);
    logic [CNT_W:0] sum;
    assign sum = {1'b0, cnt_o} + (CNT_W+1)'($countones(drop_i));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            drop_o <= '0;
            cnt_o  <= '0;
        end else begin
            drop_o <= drop_i;
            cnt_o  <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/kc_concentrator.sv
`timescale 1ns/1ps
module kc_concentrator
    import kc_pkg::*;
#(
    parameter int IN_LANES = 4,
    parameter int CONC     = 3,
    parameter int CNT_W    = 6,
    localparam int CW      = $clog2(CONC + 1)
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             sync_i,
    input  logic [IN_LANES-1:0]              in_vld_i,
    input  logic [IN_LANES-1:0][CELL_W-1:0]  in_cell_i,
    output logic [CONC-1:0]                  out_vld_o,
    output logic [CONC-1:0][CELL_W-1:0]      out_cell_o,
    output logic                             latched_o,
    output logic [IN_LANES-1:0]              drop_o,
    output logic [CNT_W-1:0]                 drop_cnt_o
);
    if (IN_LANES <= CONC) begin : g_bad_cfg
        $error("kc_concentrator needs more input lanes than output lanes");
    end

    cell_t [IN_LANES-1:0] in_cells;
    cell_t [CONC-1:0]     slots;
    cell_t [CONC-1:0]     out_cells;
    logic [CW-1:0]        store_cnt;
    logic [CW-1:0]        free;
    logic [IN_LANES-1:0]  admit;
    logic [IN_LANES-1:0]  refuse;

    assign in_cells   = in_cell_i;
    assign out_cell_o = out_cells;
    // on a tick the snapshot leaves, so the whole store is free for arrivals
    assign free = sync_i ? CW'(CONC) : CW'(CONC) - store_cnt;

    kc_admit #(.IN_LANES(IN_LANES), .CONC(CONC)) u_admit (
        .vld_i   (in_vld_i),
        .free_i  (free),
        .admit_o (admit),
        .drop_o  (refuse)
    );

    kc_store #(.IN_LANES(IN_LANES), .CONC(CONC)) u_store (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (sync_i),
        .admit_i (admit),
        .cells_i (in_cells),
        .slot_o  (slots),
        .cnt_o   (store_cnt)
    );

    kc_unload #(.CONC(CONC)) u_unload (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sync_i    (sync_i),
        .slot_i    (slots),
        .cnt_i     (store_cnt),
        .vld_o     (out_vld_o),
        .cell_o    (out_cells),
        .latched_o (latched_o)
    );

    kc_drop_ctr #(.IN_LANES(IN_LANES), .CNT_W(CNT_W)) u_drops (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .drop_i (refuse),
        .drop_o (drop_o),
        .cnt_o  (drop_cnt_o)
    );
endmodule

// File: rtl/kc_concentrator_chk.sv
`timescale 1ns/1ps
module kc_concentrator_chk #(
    parameter int IN_LANES = 4,
    parameter int CONC     = 3,
    parameter int CNT_W    = 6,
    localparam int CW      = $clog2(CONC + 1)
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                sync_i,
    input logic [IN_LANES-1:0] in_vld_i,
    input logic [CONC-1:0]     out_vld_o,
    input logic                latched_o,
    input logic [IN_LANES-1:0] drop_o,
    input logic [CNT_W-1:0]    drop_cnt_o,
    input logic [CW-1:0]       store_cnt
);
    logic [CONC-1:0] empty_lanes, empty_inc;
    assign empty_lanes = ~out_vld_o;
    assign empty_inc   = empty_lanes + CONC'(1);

    assert_store_bound_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(store_cnt) <= CONC);

    assert_drop_needs_cell_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (drop_o & ~$past(in_vld_i)) == '0);

    assert_tick_latch_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_i |=> latched_o);

    assert_top_packed_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        latched_o |-> (empty_lanes & empty_inc) == '0);

    assert_tick_empties_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (sync_i && in_vld_i == '0) |=> store_cnt == '0);

    assert_cnt_mono_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        drop_cnt_o >= $past(drop_cnt_o));

    assert_quiet_lanes_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !latched_o |-> out_vld_o == '0);
endmodule

bind kc_concentrator kc_concentrator_chk #(
    .IN_LANES(IN_LANES), .CONC(CONC), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/kc_concentrator_test.sv
`timescale 1ns/1ps
module kc_concentrator_test;
    import kc_pkg::*;

    localparam int M   = 4;
    localparam int L   = 3;
    localparam int DW  = 6;
    localparam int SAT = (1 << DW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                      rst;
    logic                      sync;
    logic [M-1:0]              in_vld;
    logic [M-1:0][CELL_W-1:0]  in_cell;
    logic [L-1:0]              out_vld;
    logic [L-1:0][CELL_W-1:0]  out_cell;
    logic                      latched;
    logic [M-1:0]              drop;
    logic [DW-1:0]             drop_cnt;

    kc_concentrator #(.IN_LANES(M), .CONC(L), .CNT_W(DW)) uut (
        .clk_i(clk), .rst_i(rst), .sync_i(sync),
        .in_vld_i(in_vld), .in_cell_i(in_cell),
        .out_vld_o(out_vld), .out_cell_o(out_cell), .latched_o(latched),
        .drop_o(drop), .drop_cnt_o(drop_cnt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    logic [CELL_W-1:0] m_slot [L];
    int                m_cnt  = 0;
    int                m_dcnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic s, input logic [M-1:0] v);
        logic [L-1:0]             e_vld;
        logic [CELL_W-1:0]        e_cell [L];
        logic [M-1:0]             e_drop;
        logic [63:0]              r;
        sync   = s;
        in_vld = v;
        for (int i = 0; i < M; i++) begin
            r = {$urandom(), $urandom()};
            in_cell[i] = r[CELL_W-1:0];
        end
        e_vld = '0;
        for (int j = 0; j < L; j++) e_cell[j] = '0;
        if (s) begin
            for (int j = 0; j < L; j++) begin
                if (j < m_cnt) begin
                    e_vld[L-1-j]  = 1'b1;
                    e_cell[L-1-j] = m_slot[j];
                end
            end
            m_cnt = 0;
        end
        e_drop = '0;
        for (int i = 0; i < M; i++) begin
            if (v[i]) begin
                if (m_cnt < L) begin
                    for (int k = L - 1; k > 0; k--) m_slot[k] = m_slot[k-1];
                    m_slot[0] = in_cell[i];
                    m_cnt++;
                end else begin
                    e_drop[i] = 1'b1;
                end
            end
        end
        m_dcnt = m_dcnt + $countones(e_drop);
        if (m_dcnt > SAT) m_dcnt = SAT;
        @(posedge clk);
        #1;
        chk(latched == s, {tag, " R4 latched"}, 64'(latched), 64'(s));
        chk(out_vld == e_vld, {tag, s ? " R5 lane valid" : " R9 lane valid"}, 64'(out_vld), 64'(e_vld));
        for (int j = 0; j < L; j++) begin
            if (e_vld[j]) chk(out_cell[j] == e_cell[j], {tag, " R5 lane cell"}, 64'(out_cell[j]), 64'(e_cell[j]));
        end
        chk(drop == e_drop, {tag, " R2 R3 drop"}, 64'(drop), 64'(e_drop));
        chk(int'(drop_cnt) == m_dcnt, {tag, " R8 drop count"}, 64'(drop_cnt), 64'(m_dcnt));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        rst = 1'b1; sync = 1'b0; in_vld = '0; in_cell = '0;
        for (int j = 0; j < L; j++) m_slot[j] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(out_vld == '0, "R1 valid in reset", 64'(out_vld), 0);
        chk(latched == 1'b0, "R1 latched in reset", 64'(latched), 0);
        chk(drop == '0 && drop_cnt == '0, "R1 drops in reset", 64'({drop, drop_cnt}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(out_vld == '0 && drop_cnt == '0, "R1 after release", 64'({out_vld, drop_cnt}), 0);
        @(negedge clk);

        step("R6 empty tick", 1'b1, 4'b0000);
        step("R3 two lanes", 1'b0, 4'b0011);
        step("R2 fill to cap", 1'b0, 4'b0100);
        step("R5 unload full", 1'b1, 4'b0000);
        step("R3 order knockout", 1'b0, 4'b1111);
        step("R2 full store", 1'b0, 4'b0001);
        step("R7 tick with arrivals", 1'b1, 4'b0110);
        step("R7 held cells out", 1'b1, 4'b0000);
        step("R6 store emptied", 1'b1, 4'b0000);
        step("R3 mid lanes", 1'b0, 4'b1010);
        step("R7 tick over partial", 1'b1, 4'b1111);
        step("R5 partial unload", 1'b0, 4'b0000);
        step("R5 tick", 1'b1, 4'b0000);

        for (int n = 0; n < 3000; n++) begin
            step("R9 random", ($urandom() % 5) == 0, 4'($urandom()));
        end

        for (int n = 0; n < 40; n++) begin
            step("R8 flood", 1'b0, 4'b1111);
        end
        chk(int'(drop_cnt) == SAT, "R8 saturated", 64'(drop_cnt), 64'(SAT));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule